// File: doc/BRIEF.md
# Fully Associative Translation Buffer with LRU Replacement

This block holds a small set of recently used virtual-to-physical page translations. Every cycle it may receive a virtual address with an access type. The virtual page number is compared against every stored tag at once. On a match the block forms the physical address in the same cycle by joining the stored physical page number to the page offset, which passes through unchanged. It also reports the status bits held for that page. On a clock edge it records the access: the page is marked referenced and, on a permitted write, modified.

When no tag matches, the block raises a miss. The surrounding control then consults the page table, which decides whether this is a plain translation miss or a real page fault. A walker returns a fill record, which the block writes into a free slot if one exists and otherwise into the least recently used slot. Writes to pages marked write-protected raise a protection fault and leave the page's modified bit as it was. A flush input empties the whole buffer in one cycle. Address width, page size and slot count are parameters; the defaults are 32-bit addresses, 4 KB pages and 16 slots.

Top module: `page_xlate_tlb`

## Requirements
- R1: After reset every slot is empty, so every lookup reports a miss and `hit`, `prot_fault`, `paddr` and the three status outputs are 0.
- R2: The page offset is the low log2(PAGE_BYTES) bits of the address. On a hit, in the same cycle, `paddr` is the stored physical page number in the upper bits with the offset copied into the low bits. For example, with 2 KB pages, address 0x00030f40 has page number 0x61 and offset 0x740.
- R3: Any page number may occupy any slot. With `lk_valid` high, `hit` is 1 when a valid slot's tag equals the page number and `miss` is 1 otherwise. With `lk_valid` low, both are 0.
- R4: `hit_ref` shows the referenced bit of the matching slot before this access. Every hit, read or write, sets that bit and makes the slot most recently used.
- R5: A write hit (`lk_write`=1) to a slot that is not write-protected sets its modified bit, as seen on `hit_dirty` at the next hit on that page. A read hit leaves the bit unchanged.
- R6: A write hit to a slot whose write-protect bit is 1 raises `prot_fault` in that cycle and leaves the modified bit unchanged. A read hit to such a slot raises no fault.
- R7: A fill (`fill_valid`=1) writes its page number, its physical page number, its modified bit and its write-protect bit into the lowest-numbered empty slot if one exists, and otherwise into the least recently used slot. The new slot's referenced bit is 0, and the slot becomes most recently used.
- R8: `flush` empties all slots at the next edge. It takes priority over a fill and over status updates in the same cycle.
- R9: When a hit and a fill fall in the same cycle, the hit's updates are applied first and the filled slot ends up most recently used. If the fill's target is the slot that hit, the fill's contents replace that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| hit | output | 1 | Translation found |
| miss | output | 1 | Lookup presented but no slot matched |
| prot_fault | output | 1 | Write to a write-protected page |
| paddr | output | PA_W | Translated physical address (0 when no hit) |
| hit_dirty | output | 1 | Modified bit of the matching slot |
| hit_ref | output | 1 | Referenced bit of the matching slot, before this access |
| hit_wprot | output | 1 | Write-protect bit of the matching slot |
| fill_valid | input | 1 | Install a fill record this cycle |
| fill_vpn | input | VA_W-log2(PAGE_BYTES) | Virtual page number of the record |
| fill_ppn | input | PA_W-log2(PAGE_BYTES) | Physical page number of the record |
| fill_dirty | input | 1 | Modified bit of the record |
| fill_wprot | input | 1 | Write-protect bit of the record |
| flush | input | 1 | Empty every slot |

## Verification
Two functions can land in the same cycle: a lookup hit and a fill. Both update the recency order and can target the same slot. The bench provokes this on purpose, including once where the hitting page is itself the least recently used slot, so the fill evicts it. The bench then watches later eviction order and status outputs against a queue-based recency model. A flush paired with a fill is provoked as well, and is judged by every following lookup missing.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Per-slot page status, mirrored from the page table entry.
    typedef struct packed {
        logic dirty;
        logic refd;
        logic wprot;
    } pstat_t;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

    localparam pstat_t PSTAT_CLEAR = '{dirty: 1'b0, refd: 1'b0, wprot: 1'b0};

endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ENTRIES-1:0]              valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]   tags,
    input  logic [VPN_W-1:0]                vpn,
    output logic [ENTRIES-1:0]              hit_vec,
    output logic                            any_hit,
    output logic [IDX_W-1:0]                hit_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == vpn);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    // R3: a page number lives in at most one slot
    p_single_match_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: rtl/tlb_age_lru.sv
module tlb_age_lru #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid,
    input  logic               touch_a_en,
    input  logic [IDX_W-1:0]   touch_a_idx,
    input  logic               touch_b_en,
    input  logic [IDX_W-1:0]   touch_b_idx,
    output logic [IDX_W-1:0]   victim_idx
);

    typedef logic [ENTRIES-1:0][IDX_W-1:0] age_arr_t;

    age_arr_t ages_q, ages_d;

    // Move slot k to age 0; every slot younger than k ages by one.
    function automatic age_arr_t promote(age_arr_t a, logic [IDX_W-1:0] k);
        age_arr_t r;
        r = a;
        for (int j = 0; j < ENTRIES; j++) begin
            if (IDX_W'(j) == k)      r[j] = '0;
            else if (a[j] < a[k])    r[j] = a[j] + 1'b1;
        end
        return r;
    endfunction

    always_comb begin
        ages_d = ages_q;
        if (touch_a_en) ages_d = promote(ages_d, touch_a_idx);
        if (touch_b_en) ages_d = promote(ages_d, touch_b_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ages_q[i] <= IDX_W'(i);
        end else begin
            ages_q <= ages_d;
        end
    end

    logic             have_free;
    logic [IDX_W-1:0] free_idx, old_idx;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        old_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
            if (ages_q[i] == IDX_W'(ENTRIES - 1)) old_idx = IDX_W'(i);
        end
    end

    assign victim_idx = have_free ? free_idx : old_idx;

    // Ages always form a permutation of 0..ENTRIES-1.
    logic [ENTRIES-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int j = 0; j < ENTRIES; j++) age_seen[ages_q[j]] = 1'b1;
    end

    // R4: recency state stays a strict order
    p_age_perm_r4: assert property (@(posedge clk) disable iff (rst)
        &age_seen);

    // R7: a filled slot is most recently used afterwards
    p_fill_mru_r7: assert property (@(posedge clk) disable iff (rst)
        touch_b_en |=> (ages_q[$past(touch_b_idx)] == '0));

    // R7: a free slot is preferred over eviction
    p_victim_free_r7: assert property (@(posedge clk) disable iff (rst)
        !(&valid) |-> !valid[victim_idx]);

endmodule

// File: rtl/page_xlate_tlb.sv
module page_xlate_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int ENTRIES    = 16,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int VPN_W     = VA_W - OFF_W,
    localparam int PPN_W     = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    output logic             hit,
    output logic             miss,
    output logic             prot_fault,
    output logic [PA_W-1:0]  paddr,
    output logic             hit_dirty,
    output logic             hit_ref,
    output logic             hit_wprot,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_dirty,
    input  logic             fill_wprot,
    input  logic             flush
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic   [ENTRIES-1:0]            valid_q;
    logic   [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic   [ENTRIES-1:0][PPN_W-1:0] ppn_q;
    pstat_t [ENTRIES-1:0]            st_q;

    logic [VPN_W-1:0] lk_vpn;
    logic [OFF_W-1:0] lk_off;
    acc_e             acc;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];
    assign acc    = acc_e'(lk_write);

    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   victim_idx;

    tlb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
        .clk     (clk),
        .rst     (rst),
        .valid   (valid_q),
        .tags    (vpn_q),
        .vpn     (lk_vpn),
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .hit_idx (hit_idx)
    );

    pstat_t cur;
    logic   fill_en, touch_hit, wr_ok;

    assign cur        = st_q[hit_idx];
    assign hit        = lk_valid && any_hit;
    assign miss       = lk_valid && !any_hit;
    assign prot_fault = hit && (acc == ACC_WRITE) && cur.wprot;
    assign wr_ok      = hit && (acc == ACC_WRITE) && !cur.wprot;
    assign paddr      = hit ? {ppn_q[hit_idx], lk_off} : '0;
    assign hit_dirty  = hit && cur.dirty;
    assign hit_ref    = hit && cur.refd;
    assign hit_wprot  = hit && cur.wprot;

    assign fill_en    = fill_valid && !flush;
    assign touch_hit  = hit && !flush;

    tlb_age_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk         (clk),
        .rst         (rst),
        .valid       (valid_q),
        .touch_a_en  (touch_hit),
        .touch_a_idx (hit_idx),
        .touch_b_en  (fill_en),
        .touch_b_idx (victim_idx),
        .victim_idx  (victim_idx)
    );

    // Valid and status: hit updates first, then fill overrides its slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) st_q[i] <= PSTAT_CLEAR;
        end else if (flush) begin
            valid_q <= '0;
        end else begin
            if (touch_hit) begin
                st_q[hit_idx].refd <= 1'b1;
                if (wr_ok) st_q[hit_idx].dirty <= 1'b1;
            end
            if (fill_en) begin
                valid_q[victim_idx] <= 1'b1;
                st_q[victim_idx]    <= '{dirty: fill_dirty, refd: 1'b0, wprot: fill_wprot};
            end
        end
    end

    // Page numbers carry no reset; valid_q guards them.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            vpn_q[victim_idx] <= fill_vpn;
            ppn_q[victim_idx] <= fill_ppn;
        end
    end

    logic fill_on_hit;
    assign fill_on_hit = fill_en && (victim_idx == hit_idx);

    // R4: a hit leaves the slot marked referenced
    p_ref_set_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && !flush && !fill_on_hit) |=> st_q[$past(hit_idx)].refd);

    // R5: permitted write hit marks the page modified
    p_dirty_set_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && lk_write && !prot_fault && !flush && !fill_on_hit)
        |=> st_q[$past(hit_idx)].dirty);

    // R6: a protected write leaves the modified bit alone
    p_prot_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (prot_fault && !flush && !fill_on_hit)
        |=> (st_q[$past(hit_idx)].dirty == $past(st_q[hit_idx].dirty)));

    // R8: flush empties everything
    p_flush_clear_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    // R3: hit and miss only with a lookup
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!hit && !miss && !prot_fault));

endmodule

// File: tb/tb_page_xlate_tlb.sv
module tb_page_xlate_tlb;

    localparam int N     = 16;
    localparam int OFF_W = 12;
    localparam int VPN_W = 20;
    localparam int PPN_W = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic             lk_valid = 0, lk_write = 0;
    logic [31:0]      lk_vaddr = '0;
    logic             hit, miss, prot_fault, hit_dirty, hit_ref, hit_wprot;
    logic [31:0]      paddr;
    logic             fill_valid = 0, fill_dirty = 0, fill_wprot = 0, flush = 0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;

    page_xlate_tlb dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .hit(hit), .miss(miss), .prot_fault(prot_fault),
        .paddr(paddr), .hit_dirty(hit_dirty), .hit_ref(hit_ref),
        .hit_wprot(hit_wprot), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_dirty(fill_dirty), .fill_wprot(fill_wprot),
        .flush(flush)
    );

    // Small 2 KB-page instance for the offset split example.
    logic        s_lkv = 0, s_fv = 0;
    logic [31:0] s_va = '0, s_pa;
    logic [20:0] s_fvpn = '0, s_fppn = '0;
    logic        s_hit, s_miss, s_pf, s_d, s_r, s_w;

    page_xlate_tlb #(.PAGE_BYTES(2048), .ENTRIES(4)) dut_2k (
        .clk(clk), .rst(rst), .lk_valid(s_lkv), .lk_vaddr(s_va),
        .lk_write(1'b0), .hit(s_hit), .miss(s_miss), .prot_fault(s_pf),
        .paddr(s_pa), .hit_dirty(s_d), .hit_ref(s_r), .hit_wprot(s_w),
        .fill_valid(s_fv), .fill_vpn(s_fvpn), .fill_ppn(s_fppn),
        .fill_dirty(1'b0), .fill_wprot(1'b0), .flush(1'b0)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: slot arrays plus a recency queue (front = newest).
    bit               m_v[N];
    logic [VPN_W-1:0] m_vpn[N];
    logic [PPN_W-1:0] m_ppn[N];
    bit               m_d[N], m_r[N], m_w[N];
    int               order[$];

    function automatic int m_find(logic [VPN_W-1:0] v);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic void m_touch(int k);
        for (int i = 0; i < order.size(); i++) begin
            if (order[i] == k) begin
                order.delete(i);
                break;
            end
        end
        order.push_front(k);
    endfunction

    function automatic void m_reset();
        order.delete();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; m_w[i] = 0;
            order.push_back(i);
        end
    endfunction

    // One cycle: drive, compare outputs against model, clock, update model.
    task automatic cyc(string tag, bit lv, logic [31:0] va, bit wr,
                       bit fv, logic [VPN_W-1:0] fvpn, logic [PPN_W-1:0] fppn,
                       bit fd, bit fw, bit fl);
        int j, vic;
        bit eh, ef;
        lk_valid = lv; lk_vaddr = va; lk_write = wr;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn;
        fill_dirty = fd; fill_wprot = fw; flush = fl;
        #1;
        j  = lv ? m_find(va[31:OFF_W]) : -1;
        eh = (j >= 0);
        ef = eh && wr && m_w[j];
        chk({tag, "/R3"}, "hit",  32'(hit),  32'(eh));
        chk({tag, "/R3"}, "miss", 32'(miss), 32'(lv && !eh));
        chk({tag, "/R2"}, "paddr", paddr, eh ? {m_ppn[j], va[OFF_W-1:0]} : 32'h0);
        chk({tag, "/R6"}, "prot_fault", 32'(prot_fault), 32'(ef));
        chk({tag, "/R5"}, "hit_dirty", 32'(hit_dirty), 32'(eh && m_d[j]));
        chk({tag, "/R4"}, "hit_ref",   32'(hit_ref),   32'(eh && m_r[j]));
        chk({tag, "/R7"}, "hit_wprot", 32'(hit_wprot), 32'(eh && m_w[j]));
        vic = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
        if (vic < 0) vic = order[$];
        @(posedge clk);
        if (fl) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else begin
            if (eh) begin
                m_r[j] = 1;
                if (wr && !m_w[j]) m_d[j] = 1;
                m_touch(j);
            end
            if (fv) begin
                m_v[vic] = 1; m_vpn[vic] = fvpn; m_ppn[vic] = fppn;
                m_d[vic] = fd; m_r[vic] = 0; m_w[vic] = fw;
                m_touch(vic);
            end
        end
        @(negedge clk);
    endtask

    task automatic look(string tag, logic [VPN_W-1:0] v, bit wr);
        cyc(tag, 1, {v, 12'h5a7}, wr, 0, '0, '0, 0, 0, 0);
    endtask

    task automatic fill(string tag, logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, bit d, bit w);
        cyc(tag, 0, '0, 0, 1, v, p, d, w, 0);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [VPN_W-1:0] lru_vpn;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: empty after reset
        look("R1", 20'h00001, 0);
        look("R1", 20'h00000, 1);

        // R2 example on the 2 KB instance
        s_fv = 1; s_fvpn = 21'h61; s_fppn = 21'h1234;
        @(negedge clk); s_fv = 0;
        s_lkv = 1; s_va = 32'h00030f40;
        #1;
        chk("R2", "2k hit", 32'(s_hit), 32'h1);
        chk("R2", "2k paddr", s_pa, 32'h0091a740);
        @(negedge clk); s_lkv = 0;

        // R2 R4 R5: basic hits, referenced and modified bits
        fill("R7", 20'h00010, 20'haaaaa, 0, 0);
        fill("R7", 20'h00020, 20'hbbbbb, 1, 0);
        fill("R7", 20'h00030, 20'hccccc, 0, 1);
        look("R4", 20'h00010, 0);
        look("R4", 20'h00010, 0);
        look("R5", 20'h00010, 1);
        look("R5", 20'h00010, 0);
        look("R5", 20'h00020, 0);
        // R6: protected page
        look("R6", 20'h00030, 0);
        look("R6", 20'h00030, 1);
        look("R6", 20'h00030, 0);
        cyc("R3", 0, 32'h00010000, 1, 0, '0, '0, 0, 0, 0);

        // R7: fill to capacity then evict by recency
        for (int i = 3; i < N; i++) fill("R7", 20'(32'h100 + i), 20'(i), 0, 0);
        look("R7", 20'h00010, 0);
        fill("R7", 20'h00777, 20'h77777, 0, 0);
        look("R7", 20'h00020, 0);
        look("R7", 20'h00010, 0);
        look("R7", 20'h00777, 0);

        // R9: hit and fill together, then hit on the slot being evicted
        cyc("R9", 1, {20'h00010, 12'h001}, 1, 1, 20'h00888, 20'h88888, 0, 0, 0);
        lru_vpn = m_vpn[order[$]];
        cyc("R9", 1, {lru_vpn, 12'h002}, 0, 1, 20'h00999, 20'h99999, 1, 0, 0);
        look("R9", lru_vpn, 0);
        look("R9", 20'h00999, 0);

        // R8: flush beats a same-cycle fill
        cyc("R8", 1, {20'h00999, 12'h0}, 1, 1, 20'h00aaa, 20'haaaaa, 0, 0, 1);
        look("R8", 20'h00999, 0);
        look("R8", 20'h00aaa, 0);
        look("R8", 20'h00010, 0);

        // Mixed traffic
        r = 32'h1234_5679;
        for (int k = 0; k < 3000; k++) begin
            logic [VPN_W-1:0] fv_vpn;
            bit do_fill, do_fl;
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            fv_vpn  = 20'(r[12:8]);
            do_fill = r[14] && (m_find(fv_vpn) < 0);
            do_fl   = (r[23:17] == 7'h0);
            cyc("mix", r[0], {15'h0, r[5:1], r[27:16]}, r[6],
                do_fill, fv_vpn, 20'(r[31:20]), r[7], r[15], do_fl);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule